// File: doc/BRIEF.md
# Clock-Source Disable Control Register

This block keeps one disable flag for each of eight clock sources. It drives the flags straight to a clock controller on `src_off`. A flag of 1 stops that source and a flag of 0 lets it run. Software reaches the same flags through three word addresses:

- A plain load register replaces every writable flag with the write data.
- A set alias turns on only the flags written as 1.
- A clear alias turns off only the flags written as 1.

Each of the three addresses reads back the current flags. Because of this, a read-modify-write is never needed.

The bus side is a single-cycle slave with no handshake. The master presents an address, a write strobe, write data and a privilege flag. A write changes the state at the clock edge on which it is presented. Read data is decoded combinationally from the stored flags. Only privileged writes are honoured. Flag 2 is reserved: it is tied to 1, and no write changes it. Flags 7..3 and 1..0 are writable.

Top module: `clksrc_gate_ctrl`

## Requirements
- R1: After reset, the flags hold 0xCE (bits 7..0 = 1,1,0,0,1,1,1,0), and every mapped address reads 0x000000CE.
- R2: Reads at 0x30, 0x34 and 0x38 all return the current flags in bits 7..0. Bits 31..8 always read 0, and write data in bits 31..8 is ignored.
- R3: Bit 2 reads 1 at every mapped address, whatever was written to it through any alias.
- R4: A privileged write to 0x30 loads bits 7..3 and 1..0 from write data bits 7..3 and 1..0.
- R5: A privileged write to 0x34 sets each writable flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: A privileged write to 0x38 clears each writable flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: A write with the privilege flag low changes no flag at any address.
- R8: A write takes effect at the edge that samples it. In the next cycle the new flags are visible at all three addresses and on `src_off`.
- R9: Any address other than 0x30, 0x34 and 0x38 reads 0, and a write to such an address changes no flag.
- R10: `src_off` always equals the stored flags, with 1 meaning the source is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High when the access is privileged |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_off | output | 8 | Disable flags to the clock controller |

## Verification
The bench writes all-ones and all-zeros through each alias to expose bit 2:
- A design that stores bit 2 would let a clear through 0x38 drop it to 0, so a read would no longer show 1.
- A design that swaps set and clear, or treats a written 0 as an active bit, would change flags that the model leaves alone.

Further traffic probes the gating:
- Unprivileged writes and writes to the neighbouring address 0x3C catch an access gate that is missing or too wide.
- Data in bits 31..8 catches a read path that leaks upper bits.

A checking model runs every cycle and samples the read one cycle after each write. This catches a design that delays the update by one cycle or that refreshes only the alias that was written.

// File: rtl/ckdis_pkg.sv
package ckdis_pkg;
  localparam int unsigned NSRC_DEF = 8;
  localparam int unsigned DATA_W   = 32;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DIRECT = 2'd1,
    SEL_SET    = 2'd2,
    SEL_CLR    = 2'd3
  } ckdis_sel_e;
endpackage

// File: rtl/ckdis_dec.sv
module ckdis_dec
  import ckdis_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] DIR_OFS = 8'h30,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h34,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h38
) (
  input  logic [ADDR_W-1:0] addr,
  output ckdis_sel_e        sel
);
  always_comb begin
    if (addr == DIR_OFS)      sel = SEL_DIRECT;
    else if (addr == SET_OFS) sel = SEL_SET;
    else if (addr == CLR_OFS) sel = SEL_CLR;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/ckdis_bits.sv
module ckdis_bits
  import ckdis_pkg::*;
#(
  parameter int unsigned   NSRC     = 8,
  parameter logic [NSRC-1:0] RST_VAL  = 8'hCE,
  parameter logic [NSRC-1:0] FIX_MASK = 8'h04
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  ckdis_sel_e      sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] flags
);
  localparam logic [NSRC-1:0] RST_EFF = RST_VAL | FIX_MASK;

  logic [NSRC-1:0] flags_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic raw_d;
    logic bit_d;
    always_comb begin
      raw_d = flags_q[i];
      if (wr_en) begin
        unique case (sel)
          SEL_DIRECT: raw_d = wdata[i];
          SEL_SET:    raw_d = flags_q[i] | wdata[i];
          SEL_CLR:    raw_d = flags_q[i] & ~wdata[i];
          default:    raw_d = flags_q[i];
        endcase
      end
      bit_d = FIX_MASK[i] | raw_d;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= RST_EFF[i];
      else        flags_q[i] <= bit_d;
    end
  end

  assign flags = flags_q;

  // R5
  set_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SET) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R6
  clr_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CLR) |=> ((flags_q | $past(flags_q)) == $past(flags_q)));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || sel == SEL_NONE) |=> $stable(flags_q));

  // R3
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & FIX_MASK) == FIX_MASK));
endmodule

// File: rtl/ckdis_rd.sv
module ckdis_rd
  import ckdis_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  ckdis_sel_e        sel,
  input  logic [NSRC-1:0]   flags,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel != SEL_NONE) rdata[NSRC-1:0] = flags;
  end
endmodule

// File: rtl/clksrc_gate_ctrl.sv
module clksrc_gate_ctrl
  import ckdis_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NSRC   = NSRC_DEF,
  parameter logic [ADDR_W-1:0] DIR_OFS = 8'h30,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h34,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h38,
  parameter logic [NSRC-1:0] RST_VAL  = 8'hCE,
  parameter logic [NSRC-1:0] FIX_MASK = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   src_off
);
  ckdis_sel_e sel;
  logic       wr_ok;
  logic       unused_hi;

  assign wr_ok     = bus_wr & bus_priv;
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

  ckdis_dec #(
    .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  ckdis_bits #(
    .NSRC(NSRC), .RST_VAL(RST_VAL), .FIX_MASK(FIX_MASK)
  ) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_ok),
    .sel  (sel),
    .wdata(bus_wdata[NSRC-1:0]),
    .flags(src_off)
  );

  ckdis_rd #(.NSRC(NSRC)) u_rd (
    .sel  (sel),
    .flags(src_off),
    .rdata(bus_rdata)
  );

  // R7
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv) |=> $stable(src_off));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[DATA_W-1:NSRC] == '0));

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr != DIR_OFS && bus_addr != SET_OFS && bus_addr != CLR_OFS)
     |-> (bus_rdata == '0)));

  // R10
  read_tracks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == DIR_OFS || bus_addr == SET_OFS || bus_addr == CLR_OFS)
     |-> (bus_rdata[NSRC-1:0] == src_off)));
endmodule

// File: tb/tb_clksrc_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clksrc_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_off;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_flags;

  always #10 clk = ~clk;

  clksrc_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .src_off(src_off)
  );

  function automatic bit mapped(input logic [7:0] a);
    return (a == 8'h30) || (a == 8'h34) || (a == 8'h38);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare before the edge, update model at edge.
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic p, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_priv = p;
    #1;
    check(tag, "rdata", bus_rdata, mapped(a) ? {24'h0, m_flags} : 32'h0);
    check("R10", "src_off", {24'h0, src_off}, {24'h0, m_flags});
    @(posedge clk);
    if (w && p) begin
      case (a)
        8'h30: m_flags = d[7:0];
        8'h34: m_flags = m_flags | d[7:0];
        8'h38: m_flags = m_flags & ~d[7:0];
        default: ;
      endcase
      m_flags[2] = 1'b1;
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_flags = 8'hCE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset value at every alias
    step(8'h30, 0, 0, 0, "R1");
    step(8'h34, 0, 0, 0, "R1");
    step(8'h38, 0, 0, 0, "R1");
    // R4 direct load
    step(8'h30, 1, 32'h0000_0000, 1, "R4");
    step(8'h34, 0, 0, 0, "R4");
    step(8'h30, 1, 32'h0000_00A9, 1, "R4");
    // R5 set alias, ones and zeros
    step(8'h34, 1, 32'h0000_0012, 1, "R5");
    step(8'h30, 0, 0, 0, "R5");
    step(8'h34, 1, 32'h0000_0000, 1, "R5");
    // R8 new value visible at all three offsets next cycle
    step(8'h30, 0, 0, 0, "R8");
    step(8'h34, 0, 0, 0, "R8");
    step(8'h38, 0, 0, 0, "R8");
    // R6 clear alias
    step(8'h38, 1, 32'h0000_0081, 1, "R6");
    step(8'h30, 0, 0, 0, "R6");
    step(8'h38, 1, 32'h0000_0000, 1, "R6");
    // R3 reserved bit survives clear-all and load-zero
    step(8'h38, 1, 32'h0000_00FF, 1, "R3");
    step(8'h38, 0, 0, 0, "R3");
    step(8'h30, 1, 32'h0000_00FB, 1, "R3");
    step(8'h34, 0, 0, 0, "R3");
    // R7 unprivileged writes
    step(8'h30, 1, 32'h0000_0000, 0, "R7");
    step(8'h34, 1, 32'h0000_00FF, 0, "R7");
    step(8'h38, 1, 32'h0000_00FF, 0, "R7");
    step(8'h30, 0, 0, 0, "R7");
    // R9 unmapped address
    step(8'h3C, 1, 32'h0000_0000, 1, "R9");
    step(8'h3C, 0, 0, 1, "R9");
    step(8'h30, 0, 0, 0, "R9");
    // R2 upper write data ignored, upper read bits zero
    step(8'h30, 1, 32'hFFFF_FF00, 1, "R2");
    step(8'h38, 0, 0, 0, "R2");
    step(8'h34, 1, 32'hA5A5_A500, 1, "R2");
    step(8'h34, 0, 0, 0, "R2");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 3));
      case (pick)
        2'd0: a = 8'h30;
        2'd1: a = 8'h34;
        2'd2: a = 8'h38;
        default: a = 8'($urandom);
      endcase
      step(a, 1'($urandom), $urandom, ($urandom_range(0, 3) != 0),
           mapped(a) ? "R2" : "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule